// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the clocked control core of one synchronous buck phase. It takes a logic-level PWM command and drives two gate enables, one for the high-side switch and one for the low-side switch. The two are never on together. The dead time between them is not a fixed count. Each gate waits for a sensed condition before it turns on. The high-side gate waits for a comparator flag that reports the low-side gate voltage is below its threshold. The low-side gate waits for a flag that reports the phase node has fallen below its threshold.

Three protections sit on top of the adaptive handoff. A forced low-side turn-on after a timeout covers reverse inductor current, where the phase node never falls. A minimum low-side off time rejects very narrow PWM pulses. A lockout holds both gates low while the supply is not qualified or the die is over temperature. The block also controls a virtual phase node output that copies the switching timing: it is driven high while the high-side gate is on, driven low while the low-side gate is on, and tristated in every commutation gap.

All five external inputs pass through a two-flop synchroniser. The supply-ready flag is then qualified by a stability filter. All delays are parameters counted in clock cycles.

Top module: `phase_gate_seq`

## Requirements
- R1: `hs_on_o` and `ls_on_o` are never both 1 in the same cycle.
- R2: When PWM rises, the low-side gate turns off first. The high-side gate stays off until `lg_low_i` is seen high. `lg_low_i` must then stay high for HS_DLY_CYC further cycles before `hs_on_o` rises.
- R3: When PWM falls, the high-side gate turns off first. The low-side gate stays off while `sw_low_i` is low, and turns on once it is seen high.
- R4: If `sw_low_i` never asserts after PWM falls, the low-side gate is forced on FORCE_ON_CYC cycles after the sequencer leaves the high-side-on state.
- R5: After a PWM rise turns the low-side gate off, that gate stays off for at least MIN_OFF_CYC cycles. A PWM pulse that ends before the high-side gate turns on returns the phase to low-side on, but no earlier than that.
- R6: While the qualified supply-ready is 0, both gates are low and the PWM input has no effect.
- R7: The supply-ready flag changes the qualified state only after it has held its new value for QUAL_CYC consecutive cycles, in either direction. A shorter pulse or dropout changes nothing.
- R8: `over_temp_i` = 1 forces both gates low within a few cycles. When it clears, the phase restarts with the low-side gate on.
- R9: Virtual phase node encoding: `vpn_en_o` = 1 means driven and 0 means tristate. `vpn_en_o` equals `hs_on_o | ls_on_o`. When driven, `vpn_hi_o` is 1 with the high-side gate and 0 with the low-side gate.
- R10: After reset, all outputs are 0. Once the supply is qualified with PWM low, `ls_on_o` = 1 and `hs_on_o` = 0.
- R11: A PWM change during a commutation does not abort it. After a falling edge, the low-side gate still turns on before a new rising edge is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | PWM command, 1 = high-side phase |
| supply_ok_i | input | 1 | Raw supply-ready flag |
| over_temp_i | input | 1 | Over-temperature flag, 1 = shut down |
| lg_low_i | input | 1 | Low-side gate voltage below threshold |
| sw_low_i | input | 1 | Phase node below threshold |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| vpn_en_o | output | 1 | Virtual phase node driver enable (0 = tristate) |
| vpn_hi_o | output | 1 | Virtual phase node level when driven |

## Verification
The hardest paths to reach are the two that hinge on a sensed flag staying put while the PWM input moves. One is the reverse-current timeout, where the phase-node flag must stay low after the high-side gate drops. The other is a narrow pulse that ends while the sequencer still waits for the low-side gate to discharge. Directed sequences hold the comparator flags by hand to reach both. Then a plant model that answers the gate outputs takes over. It runs random pulse widths, including pulses shorter than the synchroniser depth, and random reverse-current periods.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [2:0] {
    ST_LOCK,
    ST_LS_ON,
    ST_LS_BRK,
    ST_HS_WAIT,
    ST_HS_ON,
    ST_HS_BRK
  } seq_state_e;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pgs_qual.sv
module pgs_qual #(
  parameter int QUAL_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  logic          q_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(QUAL_CYC - 1)) begin
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pgs_pkg::*;
#(
  parameter int HS_DLY_CYC   = 2,
  parameter int MIN_OFF_CYC  = 8,
  parameter int FORCE_ON_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic pwm_i,
  input  logic lg_low_i,
  input  logic sw_low_i,
  output logic hs_o,
  output logic ls_o,
  output logic vpn_en_o,
  output logic vpn_hi_o
);
  localparam int TMAX = (HS_DLY_CYC > FORCE_ON_CYC) ? HS_DLY_CYC : FORCE_ON_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int MW   = $clog2(MIN_OFF_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [MW-1:0] moff_q, moff_d;
  logic          moff_ok;

  assign moff_ok = (moff_q == '0);

  always_comb begin
    state_d = state_q;
    moff_d  = moff_ok ? moff_q : moff_q - 1'b1;
    tmr_d   = (tmr_q == TW'(TMAX)) ? tmr_q : tmr_q + 1'b1;
    unique case (state_q)
      ST_LOCK:    if (moff_ok) state_d = ST_LS_ON;
      ST_LS_ON:   if (pwm_i) begin
                    state_d = ST_LS_BRK;
                    moff_d  = MW'(MIN_OFF_CYC - 1);
                  end
      ST_LS_BRK:  if (!pwm_i && moff_ok)     state_d = ST_LS_ON;
                  else if (pwm_i && lg_low_i) state_d = ST_HS_WAIT;
      ST_HS_WAIT: if (!pwm_i)                state_d = moff_ok ? ST_LS_ON : ST_LS_BRK;
                  else if (!lg_low_i)        state_d = ST_LS_BRK;
                  else if (tmr_q == TW'(HS_DLY_CYC - 1)) state_d = ST_HS_ON;
      ST_HS_ON:   if (!pwm_i) state_d = ST_HS_BRK;
      ST_HS_BRK:  if (moff_ok && (sw_low_i || tmr_q >= TW'(FORCE_ON_CYC - 1)))
                    state_d = ST_LS_ON;
      default:    state_d = ST_LOCK;
    endcase
    if (lock_i) state_d = ST_LOCK;
    if (state_d != state_q) tmr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      tmr_q   <= '0;
      moff_q  <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      moff_q  <= moff_d;
    end
  end

  assign hs_o     = (state_q == ST_HS_ON);
  assign ls_o     = (state_q == ST_LS_ON);
  assign vpn_en_o = hs_o | ls_o;
  assign vpn_hi_o = hs_o;
endmodule

// File: rtl/phase_gate_seq.sv
module phase_gate_seq #(
  parameter int SYNC_STAGES  = 2,
  parameter int HS_DLY_CYC   = 2,
  parameter int MIN_OFF_CYC  = 8,
  parameter int FORCE_ON_CYC = 20,
  parameter int QUAL_CYC     = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic supply_ok_i,
  input  logic over_temp_i,
  input  logic lg_low_i,
  input  logic sw_low_i,
  output logic hs_on_o,
  output logic ls_on_o,
  output logic vpn_en_o,
  output logic vpn_hi_o
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw, syn;
  logic pwm_s, sup_s, ot_s, lg_low_s, sw_low_s;
  logic sup_q, lock;

  assign raw = {pwm_i, supply_ok_i, over_temp_i, lg_low_i, sw_low_i};
  assign {pwm_s, sup_s, ot_s, lg_low_s, sw_low_s} = syn;

  pgs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  pgs_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk_i, .rst_ni, .d_i(sup_s), .q_o(sup_q)
  );

  assign lock = !sup_q || ot_s;

  pgs_fsm #(
    .HS_DLY_CYC(HS_DLY_CYC), .MIN_OFF_CYC(MIN_OFF_CYC), .FORCE_ON_CYC(FORCE_ON_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .lock_i(lock), .pwm_i(pwm_s), .lg_low_i(lg_low_s),
    .sw_low_i(sw_low_s), .hs_o(hs_on_o), .ls_o(ls_on_o),
    .vpn_en_o(vpn_en_o), .vpn_hi_o(vpn_hi_o)
  );
endmodule

// File: rtl/pgs_chk.sv
module pgs_chk #(
  parameter int MIN_OFF_CYC = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_i,
  input logic ls_i,
  input logic vpn_en_i,
  input logic vpn_hi_i,
  input logic lock_i,
  input logic lg_low_i
);
  localparam int OW = $clog2(MIN_OFF_CYC + 1);

  logic [OW-1:0] off_q;
  logic          ls_q, lock_q, cut_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0; ls_q <= 1'b0; lock_q <= 1'b0; cut_q <= 1'b0;
    end else begin
      ls_q   <= ls_i;
      lock_q <= lock_i;
      if (ls_i)                          off_q <= '0;
      else if (off_q != OW'(MIN_OFF_CYC)) off_q <= off_q + 1'b1;
      if (ls_q && !ls_i && !lock_q) cut_q <= 1'b1;
      else if (ls_i)                cut_q <= 1'b0;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_i && ls_i));
  p_hs_after_lg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_i) |-> $past(lg_low_i));
  p_min_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ls_i && !ls_q && cut_q) |-> (off_q >= OW'(MIN_OFF_CYC)));
  p_lock_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (!hs_i && !ls_i));
  p_vpn_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpn_en_i == (hs_i || ls_i));
  p_vpn_lvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpn_en_i |-> (vpn_hi_i == hs_i));
endmodule

bind phase_gate_seq pgs_chk #(.MIN_OFF_CYC(MIN_OFF_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_i(hs_on_o), .ls_i(ls_on_o),
  .vpn_en_i(vpn_en_o), .vpn_hi_i(vpn_hi_o), .lock_i(lock), .lg_low_i(lg_low_s)
);

// File: tb/phase_gate_seq_test.sv
module phase_gate_seq_test;
  localparam int HS_DLY  = 2;
  localparam int MIN_OFF = 8;
  localparam int FORCE   = 20;
  localparam int QUAL    = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm = 0, supply = 0, ot = 0, d_lg = 0, d_sw = 0;
  logic plant_en = 0, rev = 0, m_lg = 0, m_sw = 0;
  logic lg_low, sw_low, hs, ls, vpn_en, vpn_hi;
  int n_chk = 0, n_fail = 0, hs_rises = 0;
  bit done = 0, saw_ls;

  always #4 clk = ~clk;

  assign lg_low = plant_en ? m_lg : d_lg;
  assign sw_low = plant_en ? m_sw : d_sw;

  phase_gate_seq #(.HS_DLY_CYC(HS_DLY), .MIN_OFF_CYC(MIN_OFF),
    .FORCE_ON_CYC(FORCE), .QUAL_CYC(QUAL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .supply_ok_i(supply),
    .over_temp_i(ot), .lg_low_i(lg_low), .sw_low_i(sw_low),
    .hs_on_o(hs), .ls_on_o(ls), .vpn_en_o(vpn_en), .vpn_hi_o(vpn_hi));

  // power-stage model: gate discharge and phase-node fall one cycle late
  always @(negedge clk) if (plant_en) begin
    m_lg <= !ls;
    m_sw <= !hs && (!rev || ls);
  end

  function automatic logic [3:0] pat(input logic h, input logic l);
    return {h, l, h | l, h};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] obs();
    return {hs, ls, vpn_en, vpn_hi};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20417));
    step(3);
    chk("R10 reset outputs", obs(), pat(0, 0));
    rst_n = 1;
    step(2);
    chk("R10 idle after reset", obs(), pat(0, 0));

    // startup through qualification
    supply = 1;
    step(QUAL - 1);
    chk("R7 not yet qualified", obs(), pat(0, 0));
    step(6);
    chk("R10 startup low side on", obs(), pat(0, 1));

    // rising edge, adaptive wait on low-side gate
    pwm = 1;
    step(5);
    chk("R2 low side off first, tristate R9", obs(), pat(0, 0));
    step(20);
    chk("R2 high side waits for gate flag", obs(), pat(0, 0));
    d_lg = 1;
    step(3);
    chk("R2 fixed delay after gate flag", obs(), pat(0, 0));
    step(5);
    chk("R2 high side on, R9 driven high", obs(), pat(1, 0));

    // falling edge, adaptive wait on phase node
    pwm = 0;
    step(6);
    chk("R3 high side off, low side waits", obs(), pat(0, 0));
    d_sw = 1;
    step(4);
    chk("R3 low side on after node flag, R9 low", obs(), pat(0, 1));

    // reverse current: node never falls
    pwm = 1;
    step(15);
    chk("R2 second cycle high side", obs(), pat(1, 0));
    d_sw = 0;
    step(2);
    pwm = 0;
    step(FORCE);
    chk("R4 still waiting before timeout", obs(), pat(0, 0));
    step(5);
    chk("R4 forced low side on", obs(), pat(0, 1));

    // narrow pulse: minimum off time
    d_lg = 0;
    step(2);
    pwm = 1;
    step(1);
    pwm = 0;
    step(MIN_OFF + 1);
    chk("R5 low side held off", obs(), pat(0, 0));
    step(5);
    chk("R5 low side back after min off", obs(), pat(0, 1));

    // PWM returns high during falling commutation
    d_lg = 1;
    pwm = 1;
    step(12);
    chk("R2 high side before R11 test", obs(), pat(1, 0));
    d_sw = 0;
    pwm = 0;
    step(5);
    pwm = 1;
    step(4);
    chk("R11 commutation not aborted", obs(), pat(0, 0));
    d_sw = 1;
    saw_ls = 0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (ls) saw_ls = 1;
    end
    chk("R11 low side visited", {3'b000, saw_ls}, 4'b0001);
    chk("R11 new rise then acted on", obs(), pat(1, 0));

    // over temperature
    ot = 1;
    step(4);
    chk("R8 forced off", obs(), pat(0, 0));
    step(20);
    chk("R8 held off", obs(), pat(0, 0));
    ot = 0;
    pwm = 0;
    step(6);
    chk("R8 restart low side", obs(), pat(0, 1));

    // supply glitch shorter than qualification
    supply = 0;
    step(50);
    supply = 1;
    step(QUAL);
    chk("R7 short dropout ignored", obs(), pat(0, 1));
    supply = 0;
    step(QUAL - 1);
    chk("R7 long dropout not yet", obs(), pat(0, 1));
    step(8);
    chk("R6 lockout both low", obs(), pat(0, 0));
    pwm = 1;
    step(12);
    chk("R6 PWM ignored in lockout", obs(), pat(0, 0));
    pwm = 0;
    supply = 1;
    step(QUAL + 6);
    chk("R7 requalified, R10 startup", obs(), pat(0, 1));

    // random switching against the plant model
    plant_en = 1;
    step(2);
    for (int seg = 0; seg < 150; seg++) begin
      int hi_len, lo_len;
      hi_len = 1 + int'($urandom % 40);
      if ($urandom % 6 == 0) hi_len = 1 + int'($urandom % 3);
      lo_len = 5 + int'($urandom % 40);
      rev = ($urandom % 4 == 0);
      pwm = 1;
      for (int c = 0; c < hi_len + lo_len; c++) begin
        logic h0;
        if (c == hi_len) pwm = 0;
        h0 = hs;
        step(1);
        if (hs && !h0) hs_rises++;
        chk("R1 R9 random invariant", {hs & ls, vpn_en, vpn_hi & vpn_en, 1'b0},
            {1'b0, hs | ls, hs, 1'b0});
      end
    end
    chk("R2 random switching reached high side", {3'b000, hs_rises > 20}, 4'b0001);
    finish_run();
  end
endmodule